// File: doc/BRIEF.md
# Instruction Cache Index Parity Checker

The block inspects one index of a four-way instruction cache and reports whether any of the stored protection bits disagree with the contents they guard. A controller starts a check with a one-cycle `start` pulse, choosing through `data_en` whether the data beats are checked as well as the tags. It then streams the entries over a valid/ready input. Each way delivers a tag transfer, carrying a 32-bit high word and a 64-bit low word. When the data check is on, that tag is followed by four data beats. Each beat carries two 32-bit instructions and a 17-bit side field.

Tag checking covers three parity bits. The line-valid flag has a duplicate bit of its own. The low tag has two even-parity bits, one for the lower span and one for the upper span. Data checking covers the parity of the predecode byte and the per-byte parity of both instructions. Two sticky flags collect the results of the whole index. A one-cycle `done` pulse marks the end of the check.

Top module: `icpar_index_chk`

## Requirements
- R1: After a synchronous active-high reset the block is idle: `in_ready`, `done`, `tag_err` and `data_err` are all low.
- R2: A `start` pulse seen while idle clears both error flags at that edge and opens a check. A `start` seen while a check is running is ignored: the flags and the transfer count are unchanged.
- R3: On every tag transfer, high-tag bit 29 (line valid) must equal high-tag bit 27 (its duplicate). A mismatch sets `tag_err` whether the line is valid or not.
- R4: When high-tag bit 29 is 1, low-tag bit 10 must equal the XOR of low-tag bits 23:0, with bits 11 and 10 taken as zero. A mismatch sets `tag_err`.
- R5: When high-tag bit 29 is 1, low-tag bit 11 must equal the XOR of low-tag bits 63:24. A mismatch sets `tag_err`.
- R6: When high-tag bit 29 is 0, low-tag bits 11 and 10 are not checked.
- R7: In each data beat, side bit 16 must equal the XOR of side bits 15:8, the predecode byte. A mismatch sets `data_err`.
- R8: Side bits 7:4 guard instruction A and side bits 3:0 guard instruction B. Field bit k is the XOR of instruction byte k, so the most significant byte maps to the most significant field bit. A mismatch sets `data_err`.
- R9: With `data_en` high at start, a check takes 20 transfers in the order way 0 tag, way 0 beats 0 to 3, way 1 tag, and so on. With `data_en` low it takes the four tag transfers only, and `data_err` stays low.
- R10: `done` is high for exactly one cycle, in the cycle after the last transfer is accepted. From that cycle on, `in_ready` is low until the next start.
- R11: Both error flags hold their value from the end of a check until the next start accepted while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens an index check when idle |
| data_en | input | 1 | Sampled with start; enables the data beats |
| in_valid | input | 1 | Input transfer valid |
| in_ready | output | 1 | Block accepts a transfer |
| in_tag_hi | input | 32 | High tag word (tag transfers) |
| in_tag_lo | input | 64 | Low tag word (tag transfers) |
| in_inst_a | input | 32 | Instruction A (data beats) |
| in_inst_b | input | 32 | Instruction B (data beats) |
| in_side | input | 17 | Parity side field (data beats) |
| done | output | 1 | One-cycle end-of-check pulse |
| tag_err | output | 1 | Sticky tag or valid parity error |
| data_err | output | 1 | Sticky data-beat parity error |

## Verification
The bench builds tags whose valid duplicate disagrees on an invalid line; a design that gated the valid check with the valid bit would miss these. It also sends invalid lines with wrong span parity, which a design that checked the spans unconditionally would report. The clean indices use random values in bits 11 and 10, so a design that did not mask those bits out of the lower span would report false errors. An instruction with a single set bit in its top byte, paired with a field whose bit order is reversed, catches a checker that wires the byte parities in the wrong order. Index runs with and without data beats, and a start pulse injected mid-check, catch a sequencer that miscounts transfers, restarts while busy, or drops the sticky flags before the next start.

// File: rtl/icpar_pkg.sv
package icpar_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_TAG  = 2'd1,
      ST_BEAT = 2'd2
   } icpar_state_e;

   function automatic int unsigned icpar_cntw(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/icpar_tag_chk.sv
module icpar_tag_chk #(
   parameter int unsigned HI_W     = 32,
   parameter int unsigned LO_W     = 64,
   parameter int unsigned VLD_POS  = 29,
   parameter int unsigned VDUP_POS = 27,
   parameter int unsigned P0_POS   = 10,
   parameter int unsigned P1_POS   = 11,
   parameter int unsigned SPLIT    = 24
) (
   input  logic [HI_W-1:0] tag_hi,
   input  logic [LO_W-1:0] tag_lo,
   output logic            tag_bad
);
   localparam logic [LO_W-1:0] ONE     = {{(LO_W-1){1'b0}}, 1'b1};
   localparam logic [LO_W-1:0] LO_SPAN = (ONE << SPLIT) - ONE;
   localparam logic [LO_W-1:0] MASK0   = LO_SPAN & ~(ONE << P0_POS) & ~(ONE << P1_POS);
   localparam logic [LO_W-1:0] MASK1   = ~LO_SPAN;

   generate
      if (VLD_POS >= HI_W || VDUP_POS >= HI_W) begin : g_bad_hi
         $error("valid bit positions exceed high tag width");
      end
      if (SPLIT >= LO_W || P0_POS >= SPLIT || P1_POS >= SPLIT) begin : g_bad_lo
         $error("low tag parity layout out of range");
      end
   endgenerate

   logic line_vld, vld_mis, span0_mis, span1_mis;

   always_comb begin
      line_vld  = tag_hi[VLD_POS];
      vld_mis   = tag_hi[VLD_POS] ^ tag_hi[VDUP_POS];
      span0_mis = tag_lo[P0_POS] ^ (^(tag_lo & MASK0));
      span1_mis = tag_lo[P1_POS] ^ (^(tag_lo & MASK1));
      tag_bad   = vld_mis | (line_vld & (span0_mis | span1_mis));
   end
endmodule

// File: rtl/icpar_beat_chk.sv
module icpar_beat_chk #(
   parameter int unsigned INST_W = 32,
   parameter int unsigned PRE_W  = 8,
   localparam int unsigned NB    = INST_W / 8,
   localparam int unsigned SIDE_W = 2 * NB + PRE_W + 1
) (
   input  logic [INST_W-1:0] inst_a,
   input  logic [INST_W-1:0] inst_b,
   input  logic [SIDE_W-1:0] side,
   output logic              beat_bad
);
   generate
      if (INST_W % 8 != 0 || INST_W == 0) begin : g_bad_w
         $error("instruction width must be a whole number of bytes");
      end
   endgenerate

   logic [NB-1:0] par_a, par_b;

   for (genvar k = 0; k < NB; k++) begin : g_byte
      assign par_a[k] = ^inst_a[8*k +: 8];
      assign par_b[k] = ^inst_b[8*k +: 8];
   end

   logic [PRE_W-1:0] pre_byte;
   logic             pre_par;

   always_comb begin
      pre_byte = side[2*NB +: PRE_W];
      pre_par  = side[SIDE_W-1];
      beat_bad = (pre_par ^ (^pre_byte))
               | (|(par_a ^ side[NB +: NB]))
               | (|(par_b ^ side[0 +: NB]));
   end
endmodule

// File: rtl/icpar_seq.sv
module icpar_seq
   import icpar_pkg::*;
#(
   parameter int unsigned WAYS     = 4,
   parameter int unsigned BEATS    = 4,
   parameter bit          HAS_DATA = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic data_en,
   input  logic in_valid,
   output logic in_ready,
   output logic tag_take,
   output logic beat_take,
   output logic clr,
   output logic done
);
   localparam int unsigned WAY_W  = icpar_cntw(WAYS);
   localparam int unsigned BEAT_W = icpar_cntw(BEATS);
   localparam logic [WAY_W-1:0]  WAY_LAST  = WAY_W'(WAYS - 1);
   localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BEATS - 1);

   generate
      if (WAYS == 0 || BEATS == 0) begin : g_bad_cnt
         $error("way and beat counts must be non-zero");
      end
   endgenerate

   icpar_state_e      state_q;
   logic [WAY_W-1:0]  way_q;
   logic [BEAT_W-1:0] beat_q;
   logic              den_q, done_q, den_in, xfer;

   generate
      if (HAS_DATA) begin : g_den
         assign den_in = data_en;
      end else begin : g_noden
         assign den_in = 1'b0;
      end
   endgenerate

   assign in_ready  = (state_q != ST_IDLE);
   assign xfer      = in_valid & in_ready;
   assign tag_take  = xfer & (state_q == ST_TAG);
   assign beat_take = xfer & (state_q == ST_BEAT);
   assign clr       = start & (state_q == ST_IDLE);
   assign done      = done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         way_q   <= '0;
         beat_q  <= '0;
         den_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_TAG;
                  way_q   <= '0;
                  beat_q  <= '0;
                  den_q   <= den_in;
               end
            end
            ST_TAG: begin
               if (in_valid) begin
                  if (den_q) begin
                     state_q <= ST_BEAT;
                     beat_q  <= '0;
                  end else if (way_q == WAY_LAST) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     way_q <= way_q + 1'b1;
                  end
               end
            end
            ST_BEAT: begin
               if (in_valid) begin
                  if (beat_q != BEAT_LAST) begin
                     beat_q <= beat_q + 1'b1;
                  end else if (way_q == WAY_LAST) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     way_q   <= way_q + 1'b1;
                     state_q <= ST_TAG;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/icpar_index_chk.sv
module icpar_index_chk #(
   parameter int unsigned WAYS     = 4,
   parameter int unsigned BEATS    = 4,
   parameter bit          HAS_DATA = 1'b1,
   parameter int unsigned HI_W     = 32,
   parameter int unsigned LO_W     = 64,
   parameter int unsigned INST_W   = 32,
   parameter int unsigned PRE_W    = 8,
   localparam int unsigned SIDE_W  = 2 * (INST_W / 8) + PRE_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              data_en,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [HI_W-1:0]   in_tag_hi,
   input  logic [LO_W-1:0]   in_tag_lo,
   input  logic [INST_W-1:0] in_inst_a,
   input  logic [INST_W-1:0] in_inst_b,
   input  logic [SIDE_W-1:0] in_side,
   output logic              done,
   output logic              tag_err,
   output logic              data_err
);
   logic tag_take, beat_take, clr, tag_bad, beat_bad;

   icpar_seq #(
      .WAYS(WAYS), .BEATS(BEATS), .HAS_DATA(HAS_DATA)
   ) u_seq (
      .clk(clk), .rst(rst), .start(start), .data_en(data_en),
      .in_valid(in_valid), .in_ready(in_ready),
      .tag_take(tag_take), .beat_take(beat_take), .clr(clr), .done(done)
   );

   icpar_tag_chk #(
      .HI_W(HI_W), .LO_W(LO_W)
   ) u_tag (
      .tag_hi(in_tag_hi), .tag_lo(in_tag_lo), .tag_bad(tag_bad)
   );

   generate
      if (HAS_DATA) begin : g_data
         icpar_beat_chk #(
            .INST_W(INST_W), .PRE_W(PRE_W)
         ) u_beat (
            .inst_a(in_inst_a), .inst_b(in_inst_b), .side(in_side),
            .beat_bad(beat_bad)
         );
      end else begin : g_nodata
         assign beat_bad = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         tag_err  <= 1'b0;
         data_err <= 1'b0;
      end else begin
         if (tag_take && tag_bad)   tag_err  <= 1'b1;
         if (beat_take && beat_bad) data_err <= 1'b1;
      end
   end
endmodule

// File: rtl/icpar_index_chk_sva.sv
module icpar_index_chk_sva (
   input logic clk,
   input logic rst,
   input logic start,
   input logic in_valid,
   input logic in_ready,
   input logic done,
   input logic tag_err,
   input logic data_err
);
   // R1
   reset_idle_chk: assert property (@(posedge clk)
      rst |=> (!in_ready && !done && !tag_err && !data_err));

   // R2
   start_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (start && !in_ready) |=> (!tag_err && !data_err && in_ready));

   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> (!in_ready && $past(in_valid && in_ready)));

   // R11
   tag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (tag_err && !(start && !in_ready)) |=> tag_err);

   // R11
   data_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (data_err && !(start && !in_ready)) |=> data_err);

   // R3
   tag_rise_xfer_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(tag_err) |-> $past(in_valid && in_ready));
endmodule

bind icpar_index_chk icpar_index_chk_sva u_sva (
   .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
   .in_ready(in_ready), .done(done), .tag_err(tag_err), .data_err(data_err)
);

// File: tb/icpar_index_chk_tb.sv
module icpar_index_chk_tb;
   logic        clk = 1'b0;
   logic        rst, start, data_en, in_valid;
   logic        in_ready, done, tag_err, data_err;
   logic [31:0] in_tag_hi, in_inst_a, in_inst_b;
   logic [63:0] in_tag_lo;
   logic [16:0] in_side;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   logic [31:0] s_hi [4];
   logic [63:0] s_lo [4];
   logic [31:0] s_a  [16];
   logic [31:0] s_b  [16];
   logic [16:0] s_sd [16];

   always #5 clk = ~clk;

   icpar_index_chk u_dut (
      .clk(clk), .rst(rst), .start(start), .data_en(data_en),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_tag_hi(in_tag_hi), .in_tag_lo(in_tag_lo),
      .in_inst_a(in_inst_a), .in_inst_b(in_inst_b), .in_side(in_side),
      .done(done), .tag_err(tag_err), .data_err(data_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] bpar(input logic [31:0] w);
      return {^w[31:24], ^w[23:16], ^w[15:8], ^w[7:0]};
   endfunction

   function automatic logic [16:0] good_side(input logic [31:0] a, input logic [31:0] b,
                                             input logic [7:0] pre);
      return {^pre, pre, bpar(a), bpar(b)};
   endfunction

   function automatic logic [63:0] good_lo(input logic [63:0] raw);
      logic [63:0] r;
      logic p0, p1;
      p0 = ^(raw[23:0] & ~24'h000C00);
      p1 = ^raw[63:24];
      r = raw;
      r[10] = p0;
      r[11] = p1;
      return r;
   endfunction

   function automatic logic [31:0] mk_hi(input logic [31:0] raw, input logic v);
      logic [31:0] r;
      r = raw;
      r[29] = v;
      r[27] = v;
      return r;
   endfunction

   task automatic fill_clean();
      for (int w = 0; w < 4; w++) begin
         s_hi[w] = mk_hi($urandom, 1'b1);
         s_lo[w] = good_lo({$urandom, $urandom});
      end
      for (int i = 0; i < 16; i++) begin
         s_a[i]  = $urandom;
         s_b[i]  = $urandom;
         s_sd[i] = good_side(s_a[i], s_b[i], 8'($urandom));
      end
   endtask

   // Runs one index check; inject >= 0 pulses start at that transfer index.
   task automatic run_index(input string req, input logic den, input int inject,
                            input logic exp_tag, input logic exp_data);
      int total;
      int k;
      total = den ? 20 : 4;
      @(negedge clk);
      start = 1'b1;
      data_en = den;
      @(negedge clk);
      start = 1'b0;
      chk({req, " R2 flags clear"}, {tag_err, data_err}, 2'b00);
      chk({req, " R2 ready"}, in_ready, 1'b1);
      k = 0;
      for (int w = 0; w < 4; w++) begin
         in_valid = 1'b1;
         in_tag_hi = s_hi[w];
         in_tag_lo = s_lo[w];
         start = (k == inject);
         k++;
         @(negedge clk);
         start = 1'b0;
         if (den) begin
            for (int b = 0; b < 4; b++) begin
               in_tag_hi = $urandom;
               in_tag_lo = {$urandom, $urandom};
               in_inst_a = s_a[w*4+b];
               in_inst_b = s_b[w*4+b];
               in_side   = s_sd[w*4+b];
               start = (k == inject);
               k++;
               if (k < total) chk({req, " R9 ready mid"}, in_ready, 1'b1);
               @(negedge clk);
               start = 1'b0;
            end
         end
      end
      in_valid = 1'b0;
      chk({req, " R10 done"}, done, 1'b1);
      chk({req, " R10 ready low"}, in_ready, 1'b0);
      chk({req, " R3/R4/R5 tag_err"}, tag_err, exp_tag);
      chk({req, " R7/R8 data_err"}, data_err, exp_data);
      @(negedge clk);
      chk({req, " R10 done pulse"}, done, 1'b0);
      repeat (3) @(negedge clk);
      chk({req, " R11 sticky"}, {tag_err, data_err}, {exp_tag, exp_data});
   endtask

   task automatic t_reset();
      rst = 1'b1; start = 1'b0; data_en = 1'b0; in_valid = 1'b0;
      in_tag_hi = '0; in_tag_lo = '0; in_inst_a = '0; in_inst_b = '0; in_side = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 reset", {in_ready, done, tag_err, data_err}, 4'b0000);
   endtask

   task automatic t_clean();
      for (int r = 0; r < 3; r++) begin
         fill_clean();
         run_index("clean R4 R5 R7 R8 R9", 1'b1, -1, 1'b0, 1'b0);
      end
   endtask

   task automatic t_valid_dup();
      fill_clean();
      s_hi[2] = mk_hi($urandom, 1'b0);
      s_hi[2][27] = 1'b1;
      run_index("R3 invalid line dup", 1'b1, -1, 1'b1, 1'b0);
      fill_clean();
      s_hi[1][27] = 1'b0;
      run_index("R3 valid line dup", 1'b0, -1, 1'b1, 1'b0);
   endtask

   task automatic t_span_parity();
      fill_clean();
      s_lo[3][10] = ~s_lo[3][10];
      run_index("R4 low span", 1'b1, -1, 1'b1, 1'b0);
      fill_clean();
      s_lo[0][11] = ~s_lo[0][11];
      run_index("R5 high span", 1'b1, -1, 1'b1, 1'b0);
      fill_clean();
      s_lo[0][40] = ~s_lo[0][40];
      run_index("R5 data bit", 1'b0, -1, 1'b1, 1'b0);
   endtask

   task automatic t_invalid_ignored();
      fill_clean();
      s_hi[1] = mk_hi($urandom, 1'b0);
      s_lo[1][10] = ~s_lo[1][10];
      s_lo[1][11] = ~s_lo[1][11];
      run_index("R6 invalid spans", 1'b1, -1, 1'b0, 1'b0);
   endtask

   task automatic t_data_parity();
      fill_clean();
      s_sd[6][16] = ~s_sd[6][16];
      run_index("R7 predecode", 1'b1, -1, 1'b0, 1'b1);
      fill_clean();
      s_a[15] = 32'h0100_0000;
      s_sd[15] = {^s_sd[15][15:8], s_sd[15][15:8], 4'b0001, bpar(s_b[15])};
      run_index("R8 byte order A", 1'b1, -1, 1'b0, 1'b1);
      fill_clean();
      s_a[4] = 32'h0100_0000;
      s_sd[4] = good_side(s_a[4], s_b[4], 8'h5A);
      s_b[9] = s_b[9] ^ 32'h0000_0080;
      run_index("R8 instr B", 1'b1, -1, 1'b0, 1'b1);
   endtask

   task automatic t_no_data();
      fill_clean();
      for (int i = 0; i < 16; i++) s_sd[i] = ~s_sd[i];
      run_index("R9 tags only", 1'b0, -1, 1'b0, 1'b0);
   endtask

   task automatic t_busy_start();
      fill_clean();
      s_hi[0][27] = ~s_hi[0][27];
      run_index("R2 start while busy", 1'b1, 7, 1'b1, 1'b0);
      fill_clean();
      run_index("R2 restart clears", 1'b1, -1, 1'b0, 1'b0);
   endtask

   initial begin
      t_reset();
      t_clean();
      t_valid_dup();
      t_span_parity();
      t_invalid_ignored();
      t_data_parity();
      t_no_data();
      t_busy_start();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule